// File: doc/BRIEF.md
# Stride Prefetch Engine with In-Flight Merging

This block sits on a core's cache miss path. It receives demand byte addresses, converts them to 4-byte block addresses, and forwards each one to the next memory level over a single request port. It also watches the demand stream for a constant step. The last three demand blocks are kept, and when the step from the oldest to the middle block matches the step from the middle to the newest block and is not zero, one prefetch is raised for the block one step past the newest.

A four-entry table records every request that has been sent downstream and has not yet been answered. A demand for a block that is already in the table is accepted and absorbed without a new request. A prefetch for such a block is discarded. A completion input, tagged with the block address, frees the entry. A single pending-prefetch slot holds a prefetch until the shared port is free, and demand traffic always wins that port. Three counters report issued demands, issued prefetches and discarded prefetches, so that bandwidth overhead can be measured.

Top module: `stride_prefetch_engine`

## Requirements
- R1: After reset, `req_valid` is 0, all three counters are 0, and `dmd_ready` equals `req_ready` while no demand is presented.
- R2: The block address is the byte address shifted right by 2. An accepted demand that is not merged appears in the same cycle on the request port with `req_is_pf`=0 and `req_blk` equal to that block.
- R3: When a demand is accepted and the difference between it and the previous block equals the difference between the previous two blocks, a prefetch is raised one cycle later with `req_is_pf`=1 and `req_blk` = newest block + stride, provided the port is free.
- R4: No prefetch is raised before three demands have been accepted, or when the two differences are not equal.
- R5: A zero stride, where the same block is seen three times, raises no prefetch.
- R6: A demand for a block already in flight is accepted (`dmd_ready`=1), produces no request and is not counted.
- R7: With all 4 table entries occupied, a demand for a new block sees `dmd_ready`=0 and no request is issued. A pending prefetch found in that state is discarded.
- R8: While a demand is driving the port, a pending prefetch waits. It issues in the first cycle with no demand wanting the port.
- R9: A completion frees its entry from the next cycle on, so a stalled demand then proceeds.
- R10: Strides are differences modulo 2^30 block addresses. Descending patterns are detected, and a target past the top address wraps to low blocks.
- R11: `cnt_dmd_issued`, `cnt_pf_issued` and `cnt_pf_squashed` each step by one per demand issued, prefetch issued or prefetch discarded.
- R12: A prefetch whose target is already in flight is discarded and counted in `cnt_pf_squashed`, and it produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dmd_valid | input | 1 | Demand address valid |
| dmd_ready | output | 1 | Demand accepted this cycle |
| dmd_addr | input | 32 | Demand byte address |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream port can take a request |
| req_blk | output | 30 | Downstream request block address |
| req_is_pf | output | 1 | 1 for a prefetch, 0 for a demand |
| cpl_valid | input | 1 | Completion from downstream |
| cpl_blk | input | 30 | Block address of the completion |
| cnt_pf_issued | output | 16 | Prefetches sent downstream |
| cnt_pf_squashed | output | 16 | Prefetches merged or dropped |
| cnt_dmd_issued | output | 16 | Demands sent downstream |

## Verification
A corrupted stride history shows up on the request port one cycle after the third demand of a pattern, as a missing prefetch, a spurious one or a wrong target block. A stale or lost table entry shows within one cycle, either as a duplicate request for an in-flight block or as `dmd_ready` held low while fewer than four requests are outstanding. Counter faults appear on the counter outputs one edge after the event concerned.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic {
    SRC_DEMAND   = 1'b0,
    SRC_PREFETCH = 1'b1
  } req_src_e;
endpackage

// File: rtl/spe_stride_detect.sv
module spe_stride_detect #(
  parameter int BLK_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             trig,
  output logic [BLK_W-1:0] trig_blk
);
  logic [1:0]       fill_q, fill_nxt;
  logic [BLK_W-1:0] h_old_q, h_mid_q, h_new_q;
  logic [BLK_W-1:0] d_prev, d_cur;

  always_comb begin
    d_prev   = h_new_q - h_mid_q;
    d_cur    = acc_blk - h_new_q;
    trig     = acc_valid && (fill_q >= 2'd2) && (d_cur == d_prev) && (d_cur != '0);
    trig_blk = acc_blk + d_cur;
    fill_nxt = fill_q;
    if (acc_valid && fill_q != 2'd3) fill_nxt = fill_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= 2'd0;
    else        fill_q <= fill_nxt;
  end

  always_ff @(posedge clk) begin
    if (acc_valid) begin
      h_old_q <= h_mid_q;
      h_mid_q <= h_new_q;
      h_new_q <= acc_blk;
    end
  end

  // R3: after a trigger the stored history holds two equal nonzero steps
  a_r3_hist_stride: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ((h_new_q - h_mid_q) == (h_mid_q - h_old_q)) && (h_new_q != h_mid_q));
endmodule

// File: rtl/spe_inflight_table.sv
module spe_inflight_table #(
  parameter int BLK_W = 30,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] lk_dmd_blk,
  input  logic [BLK_W-1:0] lk_pf_blk,
  input  logic             alloc_valid,
  input  logic [BLK_W-1:0] alloc_blk,
  input  logic             cpl_valid,
  input  logic [BLK_W-1:0] cpl_blk,
  output logic             hit_dmd,
  output logic             hit_pf,
  output logic             full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_nxt;
  logic [BLK_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] m_dmd, m_pf, m_alloc, m_cpl;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign m_dmd[g]   = vld_q[g] && (tag_q[g] == lk_dmd_blk);
    assign m_pf[g]    = vld_q[g] && (tag_q[g] == lk_pf_blk);
    assign m_alloc[g] = vld_q[g] && (tag_q[g] == alloc_blk);
    assign m_cpl[g]   = vld_q[g] && cpl_valid && (tag_q[g] == cpl_blk);

    always_ff @(posedge clk) begin
      if (alloc_valid && free_idx == IDX_W'(g)) tag_q[g] <= alloc_blk;
    end
  end

  assign hit_dmd = |m_dmd;
  assign hit_pf  = |m_pf;
  assign full    = &vld_q;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
    vld_nxt = vld_q & ~m_cpl;
    if (alloc_valid) vld_nxt[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nxt;
  end

  // R7: nothing is written into a full table
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !full);
  // R12: a block already in flight is never requested a second time
  a_r12_no_dup_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (m_alloc == '0));
  // R9: a written entry is occupied on the next cycle
  a_r9_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> ($countones(vld_q) >= 1));
endmodule

// File: rtl/spe_req_arbiter.sv
module spe_req_arbiter
  import spe_pkg::*;
#(
  parameter int BLK_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dmd_valid,
  input  logic [BLK_W-1:0] dmd_blk,
  input  logic             dmd_hit,
  input  logic             pf_hit,
  input  logic             full,
  input  logic             req_ready,
  input  logic             trig,
  input  logic [BLK_W-1:0] trig_blk,
  output logic             dmd_ready,
  output logic             req_valid,
  output logic [BLK_W-1:0] req_blk,
  output req_src_e         req_src,
  output logic [BLK_W-1:0] slot_blk,
  output logic             dmd_issue,
  output logic             pf_issue,
  output logic             pf_squash
);
  logic             slot_v_q, slot_v_nxt;
  logic [BLK_W-1:0] slot_blk_q;
  logic             dmd_want, pf_want, pf_drop;

  assign slot_blk = slot_blk_q;

  always_comb begin
    dmd_want   = dmd_valid && !dmd_hit && !full;
    dmd_issue  = dmd_want && req_ready;
    dmd_ready  = dmd_hit || (!full && req_ready);
    pf_drop    = slot_v_q && (pf_hit || full);
    pf_want    = slot_v_q && !pf_drop && !dmd_want;
    pf_issue   = pf_want && req_ready;
    req_valid  = dmd_want || pf_want;
    req_src    = dmd_want ? SRC_DEMAND : SRC_PREFETCH;
    req_blk    = dmd_want ? dmd_blk : slot_blk_q;
    pf_squash  = pf_drop || (slot_v_q && !pf_issue && trig);
    slot_v_nxt = slot_v_q;
    if (trig)                     slot_v_nxt = 1'b1;
    else if (pf_drop || pf_issue) slot_v_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_v_q <= 1'b0;
    else        slot_v_q <= slot_v_nxt;
  end

  always_ff @(posedge clk) begin
    if (trig) slot_blk_q <= trig_blk;
  end

  // R8: a waiting prefetch keeps its target until it leaves
  a_r8_pf_held: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v_q && !pf_issue && !pf_drop && !trig) |=> (slot_v_q && $stable(slot_blk_q)));
  // R2: a demand issue always coincides with a handshake on the port
  a_r2_dmd_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_issue |-> (req_valid && req_ready && dmd_ready));
endmodule

// File: rtl/stride_prefetch_engine.sv
module stride_prefetch_engine
  import spe_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 2,
  parameter int DEPTH     = 4,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dmd_valid,
  output logic                        dmd_ready,
  input  logic [ADDR_W-1:0]           dmd_addr,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [ADDR_W-BLK_SHIFT-1:0] req_blk,
  output logic                        req_is_pf,
  input  logic                        cpl_valid,
  input  logic [ADDR_W-BLK_SHIFT-1:0] cpl_blk,
  output logic [CNT_W-1:0]            cnt_pf_issued,
  output logic [CNT_W-1:0]            cnt_pf_squashed,
  output logic [CNT_W-1:0]            cnt_dmd_issued
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [BLK_W-1:0] dmd_blk, slot_blk, trig_blk;
  logic             dmd_hit, pf_hit, full, trig;
  logic             dmd_issue, pf_issue, pf_squash;
  req_src_e         req_src;
  logic [CNT_W-1:0] c_pf_q, c_sq_q, c_dm_q, c_pf_nxt, c_sq_nxt, c_dm_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign dmd_blk   = dmd_addr[ADDR_W-1:BLK_SHIFT];
  assign req_is_pf = (req_src == SRC_PREFETCH);

  spe_stride_detect #(.BLK_W(BLK_W)) u_stride (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .acc_valid(dmd_valid && dmd_ready),
    .acc_blk  (dmd_blk),
    .trig     (trig),
    .trig_blk (trig_blk)
  );

  spe_inflight_table #(.BLK_W(BLK_W), .DEPTH(DEPTH)) u_table (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .lk_dmd_blk (dmd_blk),
    .lk_pf_blk  (slot_blk),
    .alloc_valid(dmd_issue || pf_issue),
    .alloc_blk  (req_blk),
    .cpl_valid  (cpl_valid),
    .cpl_blk    (cpl_blk),
    .hit_dmd    (dmd_hit),
    .hit_pf     (pf_hit),
    .full       (full)
  );

  spe_req_arbiter #(.BLK_W(BLK_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .dmd_valid(dmd_valid),
    .dmd_blk  (dmd_blk),
    .dmd_hit  (dmd_hit),
    .pf_hit   (pf_hit),
    .full     (full),
    .req_ready(req_ready),
    .trig     (trig),
    .trig_blk (trig_blk),
    .dmd_ready(dmd_ready),
    .req_valid(req_valid),
    .req_blk  (req_blk),
    .req_src  (req_src),
    .slot_blk (slot_blk),
    .dmd_issue(dmd_issue),
    .pf_issue (pf_issue),
    .pf_squash(pf_squash)
  );

  always_comb begin
    c_pf_nxt = c_pf_q + (pf_issue  ? CNT_W'(1) : CNT_W'(0));
    c_sq_nxt = c_sq_q + (pf_squash ? CNT_W'(1) : CNT_W'(0));
    c_dm_nxt = c_dm_q + (dmd_issue ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      c_pf_q <= '0;
      c_sq_q <= '0;
      c_dm_q <= '0;
    end else begin
      c_pf_q <= c_pf_nxt;
      c_sq_q <= c_sq_nxt;
      c_dm_q <= c_dm_nxt;
    end
  end

  assign cnt_pf_issued   = c_pf_q;
  assign cnt_pf_squashed = c_sq_q;
  assign cnt_dmd_issued  = c_dm_q;

  // R11: the demand counter moves only on an accepted downstream demand
  a_r11_dmd_count: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready && !req_is_pf) |=> (cnt_dmd_issued == $past(cnt_dmd_issued) + CNT_W'(1)));
  // R11: the prefetch counter moves only on an accepted downstream prefetch
  a_r11_pf_count: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(req_valid && req_ready && req_is_pf) |=> $stable(cnt_pf_issued));
  // R6: a merged demand sends nothing downstream
  a_r6_merge_silent: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dmd_valid && dmd_hit) |-> !(req_valid && !req_is_pf));
endmodule

// File: tb/stride_prefetch_engine_test.sv
module stride_prefetch_engine_test;
  logic        clk, rst_n;
  logic        dmd_valid, dmd_ready;
  logic [31:0] dmd_addr;
  logic        req_valid, req_ready, req_is_pf;
  logic [29:0] req_blk;
  logic        cpl_valid;
  logic [29:0] cpl_blk;
  logic [15:0] cnt_pf_issued, cnt_pf_squashed, cnt_dmd_issued;

  int n_run, n_fail;

  stride_prefetch_engine uut (
    .clk(clk), .rst_n(rst_n),
    .dmd_valid(dmd_valid), .dmd_ready(dmd_ready), .dmd_addr(dmd_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk), .req_is_pf(req_is_pf),
    .cpl_valid(cpl_valid), .cpl_blk(cpl_blk),
    .cnt_pf_issued(cnt_pf_issued), .cnt_pf_squashed(cnt_pf_squashed),
    .cnt_dmd_issued(cnt_dmd_issued)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NV = 15;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0000_0100, 32'h0000_0104, 32'h0000_0108, 32'h0000_011C, 32'h0000_0120,
    32'h0000_0124, 32'h0000_0124, 32'h0000_0124, 32'h0000_0118, 32'h0000_010C,
    32'h0000_0000, 32'h0000_0003, 32'hFFFF_FFF0, 32'hFFFF_FFF8, 32'h0000_0000};
  localparam logic V_PF [NV] = '{0,0,1,0,0, 1,0,0,0,1, 0,0,0,0,1};
  localparam logic [29:0] V_PFB [NV] = '{
    30'h0, 30'h0, 30'h43, 30'h0, 30'h0, 30'h4A, 30'h0, 30'h0, 30'h0, 30'h40,
    30'h0, 30'h0, 30'h0, 30'h0, 30'h2};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic dv, input logic [31:0] addr, input logic cv, input logic [29:0] cb);
    @(negedge clk);
    dmd_valid = dv;
    dmd_addr  = addr;
    cpl_valid = cv;
    cpl_blk   = cb;
    #1;
  endtask

  function automatic logic [31:0] ba(input logic [29:0] b);
    return {b, 2'b00};
  endfunction

  function automatic string vtag(input int i);
    if (i == 7)            return "R5";
    if (i == 9 || i == 14) return "R10";
    if (V_PF[i])           return "R3";
    return "R4";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dmd_valid = 0; dmd_addr = '0; cpl_valid = 0; cpl_blk = '0; req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; dmd_valid = 0; dmd_addr = '0; cpl_valid = 0; cpl_blk = '0; req_ready = 1'b1;
    do_reset();
    cyc(0, '0, 0, '0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 dmd_ready", dmd_ready, 1);
    chk("R1 cnt_pf_issued", cnt_pf_issued, 0);
    chk("R1 cnt_pf_squashed", cnt_pf_squashed, 0);
    chk("R1 cnt_dmd_issued", cnt_dmd_issued, 0);

    for (int i = 0; i < NV; i++) begin
      cyc(1, V_ADDR[i], 0, '0);
      chk("R2 req_valid", req_valid, 1);
      chk("R2 req_is_pf", req_is_pf, 0);
      chk("R2 req_blk", req_blk, V_ADDR[i][31:2]);
      cyc(0, '0, 0, '0);
      chk(vtag(i), req_valid, V_PF[i]);
      if (V_PF[i]) begin
        chk({vtag(i), " req_is_pf"}, req_is_pf, 1);
        chk({vtag(i), " req_blk"}, req_blk, V_PFB[i]);
      end
      cyc(0, '0, 1, V_ADDR[i][31:2]);
      if (V_PF[i]) cyc(0, '0, 1, V_PFB[i]);
    end
    cyc(0, '0, 0, '0);
    chk("R11 cnt_dmd_issued", cnt_dmd_issued, 15);
    chk("R11 cnt_pf_issued", cnt_pf_issued, 4);
    chk("R11 cnt_pf_squashed", cnt_pf_squashed, 0);

    // merge, full table stall, completion release
    do_reset();
    cyc(1, ba(30'h200), 0, '0);
    chk("R2 first demand", req_valid, 1);
    cyc(1, ba(30'h200), 0, '0);
    chk("R6 dmd_ready", dmd_ready, 1);
    chk("R6 req_valid", req_valid, 0);
    cyc(1, ba(30'h300), 0, '0);
    cyc(1, ba(30'h310), 0, '0);
    cyc(1, ba(30'h305), 0, '0);
    cyc(1, ba(30'h400), 0, '0);
    chk("R7 dmd_ready full", dmd_ready, 0);
    chk("R7 req_valid full", req_valid, 0);
    cyc(1, ba(30'h400), 1, 30'h300);
    chk("R7 dmd_ready same cycle as cpl", dmd_ready, 0);
    cyc(1, ba(30'h400), 0, '0);
    chk("R9 dmd_ready after cpl", dmd_ready, 1);
    chk("R9 req_blk", req_blk, 30'h400);
    cyc(0, '0, 0, '0);
    chk("R6 merged not counted", cnt_dmd_issued, 5);

    // demand priority over a waiting prefetch
    do_reset();
    cyc(1, ba(30'h10), 0, '0);
    cyc(1, ba(30'h11), 0, '0);
    cyc(1, ba(30'h12), 0, '0);
    cyc(1, ba(30'h50), 1, 30'h10);
    chk("R8 demand first src", req_is_pf, 0);
    chk("R8 demand first blk", req_blk, 30'h50);
    cyc(0, '0, 0, '0);
    chk("R8 prefetch later valid", req_valid, 1);
    chk("R8 prefetch later src", req_is_pf, 1);
    chk("R8 prefetch later blk", req_blk, 30'h13);
    cyc(0, '0, 0, '0);
    chk("R8 cnt_pf_issued", cnt_pf_issued, 1);

    // prefetch dropped on a full table
    do_reset();
    cyc(1, ba(30'h10), 0, '0);
    cyc(1, ba(30'h11), 0, '0);
    cyc(1, ba(30'h12), 0, '0);
    cyc(1, ba(30'h50), 0, '0);
    cyc(0, '0, 0, '0);
    chk("R7 pf dropped when full", req_valid, 0);
    cyc(0, '0, 0, '0);
    chk("R7 cnt_pf_squashed", cnt_pf_squashed, 1);
    chk("R7 cnt_pf_issued", cnt_pf_issued, 0);

    // prefetch target already in flight
    do_reset();
    cyc(1, ba(30'h23), 0, '0);
    cyc(1, ba(30'h20), 0, '0);
    cyc(1, ba(30'h21), 0, '0);
    cyc(1, ba(30'h22), 1, 30'h20);
    chk("R12 demand issued", req_valid, 1);
    cyc(0, '0, 0, '0);
    chk("R12 no duplicate request", req_valid, 0);
    cyc(0, '0, 0, '0);
    chk("R12 cnt_pf_squashed", cnt_pf_squashed, 1);
    chk("R12 cnt_pf_issued", cnt_pf_issued, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule